// File: doc/BRIEF.md
# Dual-Processor Interrupt Pending Selector

This block keeps the pending state of a set of interrupt sources and, for each of two processors, picks the single best request. Every source is steered by four settings, all supplied on input ports: a priority, a class, a sensitivity and a two-bit destination mask. The class is either distributed or direct/multicast. The sensitivity is either level or edge. The block qualifies each pending bit by destination, runs a priority comparison per processor, and holds the result in a per-processor candidate register. The candidate register carries a vector and a priority.

An acknowledge from a processor freezes that processor's candidate for the acknowledge cycle, so the vector it reads cannot change under it. The same acknowledge clears the pending state of the acknowledged source if that source is edge-sensitive. A distributed source owns one pending bit, which both processors see. A multicast source owns one bit per processor, and each bit is cleared only by its own processor's acknowledge. The candidate register also forms the second stage of a two-stage selection pipeline. In-service tracking, the register file and the final interrupt pin are outside this block.

Top module: `dual_irq_selector`

## Requirements
- R1: While reset is active, and at the first clock after it is released, both candidates report priority 0 and the spurious vector (default 8'hFF).
- R2: For each processor the candidate is the qualified source with the highest priority. A source with priority 0 never becomes the candidate. Among sources of equal priority, the lowest source number wins.
- R3: A distributed source (class bit 0) has one pending bit. That bit reaches processor c only when the source's destination bit `src_dest_i[s*2+c]` is 1.
- R4: A multicast source (class bit 1) has one pending bit per processor. Bit c is set only when destination bit c is 1, and it feeds only processor c.
- R5: An edge-sensitive source (sensitivity bit 1) becomes pending on a 0-to-1 transition of its line. It stays pending after the line falls.
- R6: An acknowledge by processor c whose candidate is an edge-sensitive source clears that source's pending state. For a distributed source this clears the shared bit, so the source is gone for both processors. For a multicast source only processor c's bit is cleared.
- R7: A level-sensitive source (sensitivity bit 0) is pending exactly while its line is high, as seen one clock earlier. An acknowledge does not clear it.
- R8: In the cycle `ack_i[c]` is high, processor c's candidate keeps its value. In the next cycle (with no acknowledge) it reports priority 0. After that it shows a freshly selected candidate.
- R9: A line change set up before clock edge E0 appears on the candidate outputs after edge E2, three edges later, and not before.
- R10: When no source qualifies for a processor, its candidate reports priority 0 and the spurious vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | NSRC | Request line per source |
| src_prio_i | input | NSRC*PRIO_W | Priority of source s at bits [s*PRIO_W +: PRIO_W] |
| src_vec_i | input | NSRC*VEC_W | Vector of source s at bits [s*VEC_W +: VEC_W] |
| src_multi_i | input | NSRC | Class: 0 distributed, 1 direct/multicast |
| src_edge_i | input | NSRC | Sensitivity: 0 level, 1 edge |
| src_dest_i | input | NSRC*NCPU | Destination mask, bit s*NCPU+c enables processor c |
| ack_i | input | NCPU | Acknowledge cycle per processor |
| cand_vec_o | output | NCPU*VEC_W | Candidate vector, processor c at [c*VEC_W +: VEC_W] |
| cand_prio_o | output | NCPU*PRIO_W | Candidate priority, processor c at [c*PRIO_W +: PRIO_W] |

## Verification
The bench targets several corner cases and names the fault each one would expose.

- Equal-priority sources, one pair in the same comparison half and one pair spanning both halves. A design that broke ties the wrong way, or let the upper half win on equality, would return the higher-numbered vector.
- An edge source acknowledged by one processor. If the shared bit were kept per processor, a distributed source would linger on the other processor. If the per-processor bits were shared, a multicast source would vanish from both.
- A higher-priority request timed so that it reaches the candidate register exactly on the acknowledge edge. A register that failed to freeze would swap the vector mid-acknowledge.
- A level source that is acknowledged. A design that cleared it would drop a line that is still asserted.

// File: rtl/dual_irq_sel_pkg.sv
// Shared definitions for the dual-processor interrupt pending selector.
// Assumes: class and sensitivity are single-bit encodings on the ports.
package dual_irq_sel_pkg;

    typedef enum logic {
        CLS_DIST  = 1'b0,
        CLS_MCAST = 1'b1
    } src_class_e;

    typedef enum logic {
        SENSE_LEVEL = 1'b0,
        SENSE_EDGE  = 1'b1
    } src_sense_e;

    // Index width for a count of n items (at least one bit).
    function automatic int unsigned idx_w(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/dual_irq_sel_pend.sv
// Pending-state bank.
// Holds one shared pending bit per distributed source and one bit per
// processor for each multicast source. It then qualifies each bit by the
// source's destination mask.
// Assumes: the clear strobes come from the acknowledge logic and address only
// edge-sensitive sources. When a new edge and a clear coincide, the edge wins.
module dual_irq_sel_pend
    import dual_irq_sel_pkg::*;
#(
    parameter int unsigned NSRC = 25,
    parameter int unsigned NCPU = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSRC-1:0]      irq_i,
    input  logic [NSRC-1:0]      src_multi_i,
    input  logic [NSRC-1:0]      src_edge_i,
    input  logic [NSRC*NCPU-1:0] src_dest_i,
    input  logic [NSRC-1:0]      clr_dist_i,
    input  logic [NCPU*NSRC-1:0] clr_mc_i,
    output logic [NSRC-1:0]      pend_dist_o,
    output logic [NCPU*NSRC-1:0] qual_o
);

    logic [NSRC-1:0]      irq_q;
    logic [NSRC-1:0]      rise;
    logic [NCPU*NSRC-1:0] pend_mc;

    // Previous line value, used for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= irq_i;
    end

    assign rise = irq_i & ~irq_q;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        src_class_e cls;
        src_sense_e sense;
        assign cls   = src_class_e'(src_multi_i[s]);
        assign sense = src_sense_e'(src_edge_i[s]);

        // Shared pending bit, used only by distributed sources.
        always_ff @(posedge clk) begin
            if (!rst_n)                   pend_dist_o[s] <= 1'b0;
            else if (cls != CLS_DIST)     pend_dist_o[s] <= 1'b0;
            else if (sense == SENSE_LEVEL) pend_dist_o[s] <= irq_i[s];
            else if (rise[s])             pend_dist_o[s] <= 1'b1;
            else if (clr_dist_i[s])       pend_dist_o[s] <= 1'b0;
        end

        for (genvar c = 0; c < NCPU; c++) begin : g_cpu
            localparam int unsigned BIT = c * NSRC + s;
            logic dest;
            assign dest = src_dest_i[s*NCPU + c];

            // Per-processor pending bit, used only by multicast sources.
            always_ff @(posedge clk) begin
                if (!rst_n)                    pend_mc[BIT] <= 1'b0;
                else if (cls != CLS_MCAST)     pend_mc[BIT] <= 1'b0;
                else if (sense == SENSE_LEVEL) pend_mc[BIT] <= irq_i[s] & dest;
                else if (rise[s] && dest)      pend_mc[BIT] <= 1'b1;
                else if (clr_mc_i[BIT])        pend_mc[BIT] <= 1'b0;
            end

            // Destination qualification ahead of the priority comparison.
            assign qual_o[BIT] = dest &
                ((cls == CLS_MCAST) ? pend_mc[BIT] : pend_dist_o[s]);
        end
    end

endmodule

// File: rtl/dual_irq_sel_pick.sv
// Per-processor priority selector with output request register.
// Stage 1 finds the best source within each half of the source range and
// registers it. Stage 2 merges the two halves into the output register.
// On acknowledge the output register holds and stage 1 is flushed, so a
// stale winner is never reloaded.
// Assumes: strict comparison in ascending source order, which gives priority 0
// no chance to win and sends ties to the lower source number.
module dual_irq_sel_pick #(
    parameter int unsigned           NSRC     = 25,
    parameter int unsigned           PRIO_W   = 4,
    parameter int unsigned           VEC_W    = 8,
    parameter int unsigned           SRC_W    = 5,
    parameter logic [VEC_W-1:0]      SPUR_VEC = '1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSRC-1:0]        qual_i,
    input  logic [NSRC*PRIO_W-1:0] prio_i,
    input  logic [NSRC*VEC_W-1:0]  vec_i,
    input  logic                   ack_i,
    output logic [PRIO_W-1:0]      cand_prio_o,
    output logic [VEC_W-1:0]       cand_vec_o,
    output logic [SRC_W-1:0]       cand_src_o
);

    localparam int unsigned HALF = (NSRC + 1) / 2;

    logic [1:0][PRIO_W-1:0] h_prio, s1_prio;
    logic [1:0][SRC_W-1:0]  h_src,  s1_src;
    logic [PRIO_W-1:0]      win_prio;
    logic [SRC_W-1:0]       win_src;
    logic [VEC_W-1:0]       win_vec;

    // Best qualified source within each half of the source range.
    always_comb begin
        h_prio = '0;
        h_src  = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (s < HALF) begin
                if (qual_i[s] && (prio_i[s*PRIO_W +: PRIO_W] > h_prio[0])) begin
                    h_prio[0] = prio_i[s*PRIO_W +: PRIO_W];
                    h_src[0]  = SRC_W'(s);
                end
            end else begin
                if (qual_i[s] && (prio_i[s*PRIO_W +: PRIO_W] > h_prio[1])) begin
                    h_prio[1] = prio_i[s*PRIO_W +: PRIO_W];
                    h_src[1]  = SRC_W'(s);
                end
            end
        end
    end

    // Stage 1 register, emptied by an acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || ack_i) begin
            s1_prio <= '0;
            s1_src  <= '0;
        end else begin
            s1_prio <= h_prio;
            s1_src  <= h_src;
        end
    end

    // Merge the halves; the upper half needs a strictly higher priority.
    always_comb begin
        if (s1_prio[1] > s1_prio[0]) begin
            win_prio = s1_prio[1];
            win_src  = s1_src[1];
        end else begin
            win_prio = s1_prio[0];
            win_src  = s1_src[0];
        end
        win_vec = (win_prio == '0) ? SPUR_VEC
                                   : vec_i[int'(win_src)*VEC_W +: VEC_W];
    end

    // Output request register, frozen during this processor's acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_prio_o <= '0;
            cand_vec_o  <= SPUR_VEC;
            cand_src_o  <= '0;
        end else if (!ack_i) begin
            cand_prio_o <= win_prio;
            cand_vec_o  <= win_vec;
            cand_src_o  <= win_src;
        end
    end

endmodule

// File: rtl/dual_irq_selector.sv
// Dual-processor interrupt pending selector, top level.
// Ties the pending bank to one selector per processor. It also turns each
// processor's acknowledge into a clear strobe for the acknowledged
// edge-sensitive source.
// Assumes: configuration inputs are stable while a source is pending.
module dual_irq_selector
    import dual_irq_sel_pkg::*;
#(
    parameter int unsigned      NSRC     = 25,
    parameter int unsigned      NCPU     = 2,
    parameter int unsigned      PRIO_W   = 4,
    parameter int unsigned      VEC_W    = 8,
    parameter logic [VEC_W-1:0] SPUR_VEC = '1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSRC-1:0]        irq_i,
    input  logic [NSRC*PRIO_W-1:0] src_prio_i,
    input  logic [NSRC*VEC_W-1:0]  src_vec_i,
    input  logic [NSRC-1:0]        src_multi_i,
    input  logic [NSRC-1:0]        src_edge_i,
    input  logic [NSRC*NCPU-1:0]   src_dest_i,
    input  logic [NCPU-1:0]        ack_i,
    output logic [NCPU*VEC_W-1:0]  cand_vec_o,
    output logic [NCPU*PRIO_W-1:0] cand_prio_o
);

    localparam int unsigned SRC_W = idx_w(NSRC);

    logic [NSRC-1:0]            pend_dist;
    logic [NCPU*NSRC-1:0]       qual;
    logic [NSRC-1:0]            clr_dist;
    logic [NCPU*NSRC-1:0]       clr_mc;
    logic [NCPU-1:0][SRC_W-1:0] cand_src;

    dual_irq_sel_pend #(
        .NSRC (NSRC),
        .NCPU (NCPU)
    ) u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_i       (irq_i),
        .src_multi_i (src_multi_i),
        .src_edge_i  (src_edge_i),
        .src_dest_i  (src_dest_i),
        .clr_dist_i  (clr_dist),
        .clr_mc_i    (clr_mc),
        .pend_dist_o (pend_dist),
        .qual_o      (qual)
    );

    // Acknowledge-driven clear of the edge-sensitive source held as candidate.
    always_comb begin
        clr_dist = '0;
        clr_mc   = '0;
        for (int c = 0; c < NCPU; c++) begin
            if (ack_i[c] && (cand_prio_o[c*PRIO_W +: PRIO_W] != '0) &&
                src_edge_i[cand_src[c]]) begin
                if (src_multi_i[cand_src[c]])
                    clr_mc[c*NSRC + int'(cand_src[c])] = 1'b1;
                else
                    clr_dist[cand_src[c]] = 1'b1;
            end
        end
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        dual_irq_sel_pick #(
            .NSRC     (NSRC),
            .PRIO_W   (PRIO_W),
            .VEC_W    (VEC_W),
            .SRC_W    (SRC_W),
            .SPUR_VEC (SPUR_VEC)
        ) u_pick (
            .clk         (clk),
            .rst_n       (rst_n),
            .qual_i      (qual[c*NSRC +: NSRC]),
            .prio_i      (src_prio_i),
            .vec_i       (src_vec_i),
            .ack_i       (ack_i[c]),
            .cand_prio_o (cand_prio_o[c*PRIO_W +: PRIO_W]),
            .cand_vec_o  (cand_vec_o[c*VEC_W +: VEC_W]),
            .cand_src_o  (cand_src[c])
        );
    end

endmodule

// File: rtl/dual_irq_selector_chk.sv
// Property checker for dual_irq_selector, attached by bind below.
// Assumes: it observes the top-level ports and the shared pending bits.
module dual_irq_selector_chk #(
    parameter int unsigned      NSRC     = 25,
    parameter int unsigned      NCPU     = 2,
    parameter int unsigned      PRIO_W   = 4,
    parameter int unsigned      VEC_W    = 8,
    parameter logic [VEC_W-1:0] SPUR_VEC = '1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NSRC-1:0]        irq_i,
    input logic [NSRC-1:0]        src_multi_i,
    input logic [NSRC-1:0]        src_edge_i,
    input logic [NCPU-1:0]        ack_i,
    input logic [NCPU*VEC_W-1:0]  cand_vec_o,
    input logic [NCPU*PRIO_W-1:0] cand_prio_o,
    input logic [NSRC-1:0]        pend_dist
);

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        // R1
        reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (cand_prio_o[c*PRIO_W +: PRIO_W] == '0 &&
                              cand_vec_o[c*VEC_W +: VEC_W] == SPUR_VEC));

        // R10
        spurious_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cand_prio_o[c*PRIO_W +: PRIO_W] == '0) |->
            (cand_vec_o[c*VEC_W +: VEC_W] == SPUR_VEC));

        // R8
        ack_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ack_i[c] |=> ($stable(cand_prio_o[c*PRIO_W +: PRIO_W]) &&
                          $stable(cand_vec_o[c*VEC_W +: VEC_W])));

        // R8
        ack_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_i[c] ##1 !ack_i[c]) |=> (cand_prio_o[c*PRIO_W +: PRIO_W] == '0));
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        // R7
        level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!src_edge_i[s] && !src_multi_i[s]) |=> (pend_dist[s] == $past(irq_i[s])));
    end

endmodule

bind dual_irq_selector dual_irq_selector_chk #(
    .NSRC     (NSRC),
    .NCPU     (NCPU),
    .PRIO_W   (PRIO_W),
    .VEC_W    (VEC_W),
    .SPUR_VEC (SPUR_VEC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_i       (irq_i),
    .src_multi_i (src_multi_i),
    .src_edge_i  (src_edge_i),
    .ack_i       (ack_i),
    .cand_vec_o  (cand_vec_o),
    .cand_prio_o (cand_prio_o),
    .pend_dist   (pend_dist)
);

// File: tb/dual_irq_selector_tb.sv
// Scoreboard bench: stimulus tasks push expected candidates into a queue and
// a monitor process pops and compares them against the outputs.
module dual_irq_selector_tb;

    localparam int unsigned NSRC = 25;
    localparam int unsigned NCPU = 2;
    localparam int unsigned PW   = 4;
    localparam int unsigned VW   = 8;
    localparam logic [7:0]  SPUR = 8'hFF;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [NSRC-1:0]      irq;
    logic [NSRC*PW-1:0]   prio;
    logic [NSRC*VW-1:0]   vec;
    logic [NSRC-1:0]      multi;
    logic [NSRC-1:0]      edg;
    logic [NSRC*NCPU-1:0] dest;
    logic [NCPU-1:0]      ack;
    logic [NCPU*VW-1:0]   cvec;
    logic [NCPU*PW-1:0]   cprio;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    typedef struct {
        string      tag;
        bit         use0;
        logic [7:0] v0;
        logic [3:0] p0;
        bit         use1;
        logic [7:0] v1;
        logic [3:0] p1;
    } exp_t;

    exp_t sb[$];

    // 200 MHz clock.
    always #2.5 clk = ~clk;

    dual_irq_selector #(
        .NSRC (NSRC), .NCPU (NCPU), .PRIO_W (PW), .VEC_W (VW), .SPUR_VEC (SPUR)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_i       (irq),
        .src_prio_i  (prio),
        .src_vec_i   (vec),
        .src_multi_i (multi),
        .src_edge_i  (edg),
        .src_dest_i  (dest),
        .ack_i       (ack),
        .cand_vec_o  (cvec),
        .cand_prio_o (cprio)
    );

    function automatic logic [7:0] V(input int s);
        return 8'h40 + 8'(s);
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input int s, input int p, input bit m, input bit e,
                       input bit [1:0] d);
        prio[s*PW +: PW]     = PW'(p);
        multi[s]             = m;
        edg[s]               = e;
        dest[s*NCPU +: NCPU] = d;
    endtask

    // Push an expectation; the monitor compares it in the same time step.
    task automatic expect_c(input string tag, input bit u0, input logic [7:0] v0,
                            input logic [3:0] p0, input bit u1,
                            input logic [7:0] v1, input logic [3:0] p1);
        exp_t e;
        e.tag = tag; e.use0 = u0; e.v0 = v0; e.p0 = p0;
        e.use1 = u1; e.v1 = v1; e.p1 = p1;
        sb.push_back(e);
        #0;
    endtask

    task automatic pulse(input int s);
        irq[s] = 1'b1;
        step(1);
        irq[s] = 1'b0;
    endtask

    task automatic ack_pulse(input int c);
        ack[c] = 1'b1;
        step(1);
        ack[c] = 1'b0;
    endtask

    // Monitor: pop expectations and compare against the candidate outputs.
    initial begin
        forever begin
            exp_t e;
            wait (sb.size() != 0);
            e = sb.pop_front();
            if (e.use0) begin
                checks++;
                if (cvec[7:0] !== e.v0 || cprio[3:0] !== e.p0) begin
                    fails++;
                    $display("FAIL %s cpu0: got vec=%h prio=%0d expected vec=%h prio=%0d",
                             e.tag, cvec[7:0], cprio[3:0], e.v0, e.p0);
                end
            end
            if (e.use1) begin
                checks++;
                if (cvec[15:8] !== e.v1 || cprio[7:4] !== e.p1) begin
                    fails++;
                    $display("FAIL %s cpu1: got vec=%h prio=%0d expected vec=%h prio=%0d",
                             e.tag, cvec[15:8], cprio[7:4], e.v1, e.p1);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        irq = '0; ack = '0; multi = '0; edg = '0; dest = '0; prio = '0;
        for (int s = 0; s < NSRC; s++) vec[s*VW +: VW] = V(s);
        step(3);
        rst_n = 1'b1;
        expect_c("R1 reset state", 1, SPUR, 0, 1, SPUR, 0);

        // R9 latency and R3/R7 level distributed to both processors.
        cfg(3, 5, 0, 0, 2'b11);
        irq[3] = 1'b1;
        step(2);
        expect_c("R9 not visible before third edge", 1, SPUR, 0, 1, SPUR, 0);
        step(1);
        expect_c("R9 R3 R7 level distributed", 1, V(3), 5, 1, V(3), 5);

        // R3 destination mask restricts a distributed source to cpu0.
        cfg(7, 9, 0, 0, 2'b01);
        irq[7] = 1'b1;
        step(4);
        expect_c("R3 destination qualification", 1, V(7), 9, 1, V(3), 5);

        // R2 ties within a half and across halves, and priority 0 never wins.
        cfg(10, 9, 0, 0, 2'b11);
        cfg(15, 9, 0, 0, 2'b10);
        cfg(20, 0, 0, 0, 2'b11);
        irq[10] = 1'b1; irq[15] = 1'b1; irq[20] = 1'b1;
        step(4);
        expect_c("R2 tie to lower source", 1, V(7), 9, 1, V(10), 9);

        // R8 hold then flush on cpu1; R7 level source survives acknowledge.
        ack_pulse(1);
        expect_c("R8 hold during ack", 1, V(7), 9, 1, V(10), 9);
        step(1);
        expect_c("R8 flush after ack", 0, 0, 0, 1, SPUR, 0);
        step(1);
        expect_c("R7 level not cleared by ack", 0, 0, 0, 1, V(10), 9);

        // R7 level follows line low; R10 empty gives spurious vector.
        irq = '0;
        step(4);
        expect_c("R10 R7 lines low", 1, SPUR, 0, 1, SPUR, 0);

        // R5 edge distributed stays pending; R6 ack clears shared bit.
        cfg(2, 6, 0, 1, 2'b11);
        pulse(2);
        step(3);
        expect_c("R5 edge latched", 1, V(2), 6, 1, V(2), 6);
        ack_pulse(0);
        expect_c("R8 hold edge ack", 1, V(2), 6, 0, 0, 0);
        step(3);
        expect_c("R6 distributed cleared for both", 1, SPUR, 0, 1, SPUR, 0);

        // R4 multicast edge; R6 per-processor clear.
        cfg(5, 4, 1, 1, 2'b11);
        pulse(5);
        step(3);
        expect_c("R4 multicast both", 1, V(5), 4, 1, V(5), 4);
        ack_pulse(0);
        step(3);
        expect_c("R6 multicast cleared cpu0 only", 1, SPUR, 0, 1, V(5), 4);
        ack_pulse(1);
        step(3);
        expect_c("R6 multicast cleared cpu1", 1, SPUR, 0, 1, SPUR, 0);

        // R4 multicast to cpu0 only.
        cfg(6, 8, 1, 1, 2'b01);
        pulse(6);
        step(3);
        expect_c("R4 multicast single destination", 1, V(6), 8, 1, SPUR, 0);
        ack_pulse(0);
        step(3);
        expect_c("R6 multicast single cleared", 1, SPUR, 0, 1, SPUR, 0);

        // R8 freeze while a higher request reaches the output stage.
        cfg(1, 3, 0, 0, 2'b11);
        irq[1] = 1'b1;
        step(4);
        expect_c("R2 single level winner", 1, V(1), 3, 1, V(1), 3);
        cfg(8, 12, 0, 0, 2'b11);
        irq[8] = 1'b1;
        step(2);
        ack[0] = 1'b1;
        step(1);
        ack[0] = 1'b0;
        expect_c("R8 frozen vs R9 update", 1, V(1), 3, 1, V(8), 12);
        step(1);
        expect_c("R8 flush cycle", 1, SPUR, 0, 0, 0, 0);
        step(1);
        expect_c("R8 reselect after ack", 1, V(8), 12, 0, 0, 0);

        // R10 and R4: multicast with empty mask plus a priority-0 source.
        irq = '0;
        cfg(9, 15, 1, 0, 2'b00);
        irq[9] = 1'b1; irq[20] = 1'b1;
        step(4);
        expect_c("R10 R4 nothing qualifies", 1, SPUR, 0, 1, SPUR, 0);

        wait (sb.size() == 0);
        #1;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule